// File: doc/BRIEF.md
# Warp Issue Scheduler with Register Scoreboard

This block is one issue scheduler of a compute core. It serves a fixed group of warps that never move to another scheduler. Each warp has a one-entry instruction slot, filled through a valid/ready fetch handshake. The fetch side supplies an operation class, a destination register and two source registers. In every cycle the scheduler picks at most one eligible warp and dispatches its instruction to one of three execution unit sets: single-precision float, integer or matrix. A 32-thread instruction runs on a 16-lane unit set, so it holds that set for two cycles. A float and an integer instruction can therefore be in flight in the same cycle.

A warp is eligible when three conditions hold: its slot holds an instruction, its target unit set is not in the second half of an earlier instruction, and none of its registers is waiting on a producer. For each warp and register the scoreboard keeps a countdown of remaining latency. Issue loads the countdown and it runs down to zero. Warps are picked round-robin, and the search starts just after the warp that issued last. When nothing is eligible the dispatch outputs carry a bubble.

The design holds two kinds of state machine. Each warp slot is `SLOT_EMPTY` or `SLOT_HELD`. A load moves it from EMPTY to HELD. An issue with no load in the same cycle moves it from HELD to EMPTY. An issue together with a load keeps it HELD. Each unit set is `U_IDLE` or `U_HALF2`. A dispatch moves it from IDLE to HALF2, and it always returns from HALF2 to IDLE on the next cycle. The reserved class code 3 is routed like an integer instruction.

Top module: `warp_issue_sched`

## Requirements
- R1: A synchronous reset empties every warp slot, returns every unit set to idle, clears all scoreboard counters and points the round-robin search at warp 0. After reset no dispatch valid is high and every fetch_ready bit is high. An instruction loaded right after reset issues at once, even if its sources were pending before the reset.
- R2: fetch_ready of a warp is high when its slot is empty or when that warp issues in the current cycle. An instruction is taken when valid and ready are both high at a clock edge, and it can dispatch from the following cycle on.
- R3: At most one instruction issues per cycle. The class code selects the dispatch valid bit: 0 is float (bit 0), 1 is integer (bit 1), 2 is matrix (bit 2). disp_warp, disp_dst, disp_src0 and disp_src1 show the issuing warp and its register IDs.
- R4: Among eligible warps, the scheduler picks the first one found in increasing order after the warp that issued last, wrapping from the highest warp to warp 0.
- R5: If an instruction reads a register written by an earlier instruction of the same warp, it issues no sooner than the producer's class latency after the producer issued. That latency is 4 cycles for float, 4 for integer and 8 for matrix. It issues in exactly that cycle if nothing else blocks it.
- R6: An instruction whose destination is still pending in the scoreboard of its own warp waits under the same rule as a read.
- R7: The scoreboard is kept per warp. A pending register in one warp does not hold back another warp that names the same register ID.
- R8: In the cycle after a dispatch to a unit set, that set accepts no new instruction. A different set may accept one in that cycle.
- R9: When no warp is eligible, all dispatch valid bits are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_valid | input | NUM_WARPS | Per-warp instruction offer |
| fetch_class | input | NUM_WARPS x 2 | Per-warp operation class (0 float, 1 integer, 2 matrix) |
| fetch_dst | input | NUM_WARPS x log2(NUM_REGS) | Per-warp destination register |
| fetch_src0 | input | NUM_WARPS x log2(NUM_REGS) | Per-warp first source register |
| fetch_src1 | input | NUM_WARPS x log2(NUM_REGS) | Per-warp second source register |
| fetch_ready | output | NUM_WARPS | Per-warp slot can take an instruction |
| disp_valid | output | 3 | Dispatch strobe per unit set (float, integer, matrix) |
| disp_warp | output | log2(NUM_WARPS) | Issuing warp |
| disp_dst | output | log2(NUM_REGS) | Destination of the dispatched instruction |
| disp_src0 | output | log2(NUM_REGS) | First source of the dispatched instruction |
| disp_src1 | output | log2(NUM_REGS) | Second source of the dispatched instruction |

## Verification
The bench times dependent instructions after float, integer and matrix producers and requires each to issue on the exact cycle the latency runs out. A scoreboard loaded with the wrong value would issue a cycle early or late, and one that skipped the destination check would let a write-after-write through. It places a float issue inside the second half of an integer instruction and holds an integer instruction behind a busy integer set, which exposes a busy flag shared between sets or one that never blocks. It walks the round-robin pointer across a wrap from warp 7 to warp 0, resets with a slot held and a register pending, and tests a second warp reading a register that is pending in another warp. A wrong start point, a pointer that does not wrap, or a scoreboard that is not kept per warp would each give a different warp order or an extra stall.

// File: rtl/wis_pkg.sv
package wis_pkg;

    localparam int NUM_UNITS = 3;

    typedef enum logic [1:0] {
        CLS_FP  = 2'd0,
        CLS_INT = 2'd1,
        CLS_MAT = 2'd2,
        CLS_RSV = 2'd3
    } op_class_e;

    typedef enum logic {
        U_IDLE  = 1'b0,
        U_HALF2 = 1'b1
    } unit_state_e;

    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;

    // Unit set index for a class: 0 float, 1 integer, 2 matrix.
    function automatic logic [1:0] unit_of(input op_class_e c);
        logic [1:0] u;
        unique case (c)
            CLS_FP:  u = 2'd0;
            CLS_INT: u = 2'd1;
            CLS_MAT: u = 2'd2;
            CLS_RSV: u = 2'd1;
        endcase
        return u;
    endfunction

endpackage

// File: rtl/wis_slots.sv
module wis_slots
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int REG_W     = 4
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic [NUM_WARPS-1:0]                fetch_valid,
    input  logic [NUM_WARPS-1:0][1:0]           fetch_class,
    input  logic [NUM_WARPS-1:0][REG_W-1:0]     fetch_dst,
    input  logic [NUM_WARPS-1:0][REG_W-1:0]     fetch_src0,
    input  logic [NUM_WARPS-1:0][REG_W-1:0]     fetch_src1,
    input  logic [NUM_WARPS-1:0]                issue_hot,
    output logic [NUM_WARPS-1:0]                fetch_ready,
    output logic [NUM_WARPS-1:0]                slot_full,
    output logic [NUM_WARPS-1:0][1:0]           slot_class,
    output logic [NUM_WARPS-1:0][REG_W-1:0]     slot_dst,
    output logic [NUM_WARPS-1:0][REG_W-1:0]     slot_src0,
    output logic [NUM_WARPS-1:0][REG_W-1:0]     slot_src1
);

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
        slot_state_e state_q, state_d;
        logic        load;

        assign fetch_ready[w] = (state_q == SLOT_EMPTY) || issue_hot[w];
        assign load           = fetch_valid[w] && fetch_ready[w];
        assign slot_full[w]   = (state_q == SLOT_HELD);

        always_comb begin
            state_d = state_q;
            unique case (state_q)
                SLOT_EMPTY: if (load) state_d = SLOT_HELD;
                SLOT_HELD:  if (issue_hot[w] && !load) state_d = SLOT_EMPTY;
            endcase
        end

        always_ff @(posedge clk) begin
            if (rst) state_q <= SLOT_EMPTY;
            else     state_q <= state_d;
        end

        always_ff @(posedge clk) begin
            if (load) begin
                slot_class[w] <= fetch_class[w];
                slot_dst[w]   <= fetch_dst[w];
                slot_src0[w]  <= fetch_src0[w];
                slot_src1[w]  <= fetch_src1[w];
            end
        end
    end

endmodule

// File: rtl/wis_scoreboard.sv
module wis_scoreboard #(
    parameter int NUM_WARPS = 8,
    parameter int NUM_REGS  = 16,
    parameter int WARP_W    = 3,
    parameter int REG_W     = 4,
    parameter int CNT_W     = 3
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            issue_en,
    input  logic [WARP_W-1:0]               issue_warp,
    input  logic [REG_W-1:0]                issue_dst,
    input  logic [CNT_W-1:0]                issue_wait,
    input  logic [NUM_WARPS-1:0][REG_W-1:0] q_dst,
    input  logic [NUM_WARPS-1:0][REG_W-1:0] q_src0,
    input  logic [NUM_WARPS-1:0][REG_W-1:0] q_src1,
    output logic [NUM_WARPS-1:0]            hazard
);

    logic [CNT_W-1:0] remain [NUM_WARPS][NUM_REGS];

    for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
        for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
            logic hit;
            assign hit = issue_en && (issue_warp == WARP_W'(w)) && (issue_dst == REG_W'(r));

            always_ff @(posedge clk) begin
                if (rst)
                    remain[w][r] <= '0;
                else if (hit)
                    remain[w][r] <= issue_wait;
                else if (remain[w][r] != '0)
                    remain[w][r] <= remain[w][r] - 1'b1;
            end
        end

        assign hazard[w] = (remain[w][q_src0[w]] != '0)
                        || (remain[w][q_src1[w]] != '0)
                        || (remain[w][q_dst[w]]  != '0);
    end

endmodule

// File: rtl/wis_unit_fsm.sv
module wis_unit_fsm
    import wis_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic take,
    output logic busy
);

    unit_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            U_IDLE:  if (take) state_d = U_HALF2;
            U_HALF2: state_d = U_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= U_IDLE;
        else     state_q <= state_d;
    end

    assign busy = (state_q == U_HALF2);

endmodule

// File: rtl/wis_rr_arbiter.sv
module wis_rr_arbiter #(
    parameter int NUM_WARPS = 8,
    parameter int WARP_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] elig,
    output logic                 grant_en,
    output logic [WARP_W-1:0]    grant_idx
);

    localparam int IW = WARP_W + 1;

    logic [WARP_W-1:0] last_q;

    always_comb begin
        grant_en  = 1'b0;
        grant_idx = '0;
        for (int k = 1; k <= NUM_WARPS; k++) begin
            logic [IW-1:0] j;
            j = {1'b0, last_q} + IW'(k);
            if (j >= IW'(NUM_WARPS)) j = j - IW'(NUM_WARPS);
            if (!grant_en && elig[j[WARP_W-1:0]]) begin
                grant_en  = 1'b1;
                grant_idx = j[WARP_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           last_q <= WARP_W'(NUM_WARPS - 1);
        else if (grant_en) last_q <= grant_idx;
    end

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int NUM_REGS  = 16,
    parameter int FP_LAT    = 4,
    parameter int INT_LAT   = 4,
    parameter int MAT_LAT   = 8
) (
    input  logic                                           clk,
    input  logic                                           rst,
    input  logic [NUM_WARPS-1:0]                           fetch_valid,
    input  logic [NUM_WARPS-1:0][1:0]                      fetch_class,
    input  logic [NUM_WARPS-1:0][$clog2(NUM_REGS)-1:0]     fetch_dst,
    input  logic [NUM_WARPS-1:0][$clog2(NUM_REGS)-1:0]     fetch_src0,
    input  logic [NUM_WARPS-1:0][$clog2(NUM_REGS)-1:0]     fetch_src1,
    output logic [NUM_WARPS-1:0]                           fetch_ready,
    output logic [2:0]                                     disp_valid,
    output logic [$clog2(NUM_WARPS)-1:0]                   disp_warp,
    output logic [$clog2(NUM_REGS)-1:0]                    disp_dst,
    output logic [$clog2(NUM_REGS)-1:0]                    disp_src0,
    output logic [$clog2(NUM_REGS)-1:0]                    disp_src1
);

    localparam int WARP_W  = $clog2(NUM_WARPS);
    localparam int REG_W   = $clog2(NUM_REGS);
    localparam int MAX_LAT = (FP_LAT > INT_LAT)
                           ? ((FP_LAT > MAT_LAT) ? FP_LAT : MAT_LAT)
                           : ((INT_LAT > MAT_LAT) ? INT_LAT : MAT_LAT);
    localparam int CNT_W   = $clog2(MAX_LAT);

    logic [NUM_WARPS-1:0]             slot_full;
    logic [NUM_WARPS-1:0][1:0]        slot_class;
    logic [NUM_WARPS-1:0][REG_W-1:0]  slot_dst;
    logic [NUM_WARPS-1:0][REG_W-1:0]  slot_src0;
    logic [NUM_WARPS-1:0][REG_W-1:0]  slot_src1;
    logic [NUM_WARPS-1:0]             hazard;
    logic [NUM_WARPS-1:0]             elig;
    logic [NUM_WARPS-1:0]             issue_hot;
    logic [NUM_UNITS-1:0]             unit_busy;
    logic                             grant_en;
    logic [WARP_W-1:0]                grant_idx;
    logic [1:0]                       sel_unit;
    logic [CNT_W-1:0]                 sel_wait;

    wis_slots #(
        .NUM_WARPS (NUM_WARPS),
        .REG_W     (REG_W)
    ) u_slots (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid),
        .fetch_class (fetch_class),
        .fetch_dst   (fetch_dst),
        .fetch_src0  (fetch_src0),
        .fetch_src1  (fetch_src1),
        .issue_hot   (issue_hot),
        .fetch_ready (fetch_ready),
        .slot_full   (slot_full),
        .slot_class  (slot_class),
        .slot_dst    (slot_dst),
        .slot_src0   (slot_src0),
        .slot_src1   (slot_src1)
    );

    wis_scoreboard #(
        .NUM_WARPS (NUM_WARPS),
        .NUM_REGS  (NUM_REGS),
        .WARP_W    (WARP_W),
        .REG_W     (REG_W),
        .CNT_W     (CNT_W)
    ) u_scoreboard (
        .clk        (clk),
        .rst        (rst),
        .issue_en   (grant_en),
        .issue_warp (grant_idx),
        .issue_dst  (slot_dst[grant_idx]),
        .issue_wait (sel_wait),
        .q_dst      (slot_dst),
        .q_src0     (slot_src0),
        .q_src1     (slot_src1),
        .hazard     (hazard)
    );

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        wis_unit_fsm u_unit (
            .clk  (clk),
            .rst  (rst),
            .take (disp_valid[u]),
            .busy (unit_busy[u])
        );
    end

    always_comb begin
        for (int w = 0; w < NUM_WARPS; w++) begin
            elig[w] = slot_full[w] && !hazard[w]
                   && !unit_busy[unit_of(op_class_e'(slot_class[w]))];
        end
    end

    wis_rr_arbiter #(
        .NUM_WARPS (NUM_WARPS),
        .WARP_W    (WARP_W)
    ) u_arbiter (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .grant_en  (grant_en),
        .grant_idx (grant_idx)
    );

    assign sel_unit = unit_of(op_class_e'(slot_class[grant_idx]));

    always_comb begin
        unique case (sel_unit)
            2'd0:    sel_wait = CNT_W'(FP_LAT - 1);
            2'd2:    sel_wait = CNT_W'(MAT_LAT - 1);
            default: sel_wait = CNT_W'(INT_LAT - 1);
        endcase
    end

    always_comb begin
        issue_hot = '0;
        if (grant_en) issue_hot[grant_idx] = 1'b1;
        for (int u = 0; u < NUM_UNITS; u++) begin
            disp_valid[u] = grant_en && (sel_unit == 2'(u));
        end
    end

    assign disp_warp = grant_idx;
    assign disp_dst  = slot_dst[grant_idx];
    assign disp_src0 = slot_src0[grant_idx];
    assign disp_src1 = slot_src1[grant_idx];

endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
    parameter int NUM_WARPS = 8,
    parameter int WARP_W    = 3,
    parameter int REG_W     = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_WARPS-1:0] fetch_ready,
    input logic [2:0]           disp_valid,
    input logic [WARP_W-1:0]    disp_warp,
    input logic [REG_W-1:0]     disp_dst,
    input logic [REG_W-1:0]     disp_src0,
    input logic [REG_W-1:0]     disp_src1
);

    p_post_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (disp_valid == 3'b000));

    p_issue_frees_slot_r2: assert property (@(posedge clk) disable iff (rst)
        (|disp_valid) |-> fetch_ready[disp_warp]);

    p_single_issue_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(disp_valid));

    p_fp_no_back_to_back_raw_r5: assert property (@(posedge clk) disable iff (rst)
        ((|disp_valid) && $past(disp_valid[0]) && (disp_warp == $past(disp_warp)))
        |-> ((disp_src0 != $past(disp_dst)) && (disp_src1 != $past(disp_dst))));

    p_fp_half2_r8: assert property (@(posedge clk) disable iff (rst)
        disp_valid[0] |=> !disp_valid[0]);

    p_int_half2_r8: assert property (@(posedge clk) disable iff (rst)
        disp_valid[1] |=> !disp_valid[1]);

    p_mat_half2_r8: assert property (@(posedge clk) disable iff (rst)
        disp_valid[2] |=> !disp_valid[2]);

endmodule

bind warp_issue_sched wis_checker #(
    .NUM_WARPS (NUM_WARPS),
    .WARP_W    (WARP_W),
    .REG_W     (REG_W)
) u_wis_checker (
    .clk         (clk),
    .rst         (rst),
    .fetch_ready (fetch_ready),
    .disp_valid  (disp_valid),
    .disp_warp   (disp_warp),
    .disp_dst    (disp_dst),
    .disp_src0   (disp_src0),
    .disp_src1   (disp_src1)
);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;

    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int RW = 4;
    localparam int NVEC = 29;

    typedef struct packed {
        logic [7:0] fv;
        logic [1:0] cls;
        logic [3:0] dst;
        logic [3:0] s0;
        logic [3:0] s1;
        logic [2:0] ev;
        logic [2:0] ew;
        logic [3:0] ed;
        logic [7:0] er;
        logic [3:0] rq;
    } vec_t;

    // Inputs are driven after the outputs are compared, so each row's
    // expectation reflects the rows before it. Float=001, integer=010, matrix=100.
    localparam vec_t VT [NVEC] = '{
        '{8'h01, 2'd0, 4'd1, 4'd2,  4'd3,  3'b000, 3'd0, 4'd0, 8'hFF, 4'd2}, // 0  R2 load w0 FP
        '{8'h01, 2'd0, 4'd4, 4'd1,  4'd5,  3'b001, 3'd0, 4'd1, 8'hFF, 4'd3}, // 1  R3 issue, load dependent
        '{8'h02, 2'd1, 4'd9, 4'd1,  4'd1,  3'b000, 3'd0, 4'd0, 8'hFE, 4'd5}, // 2  R5 stall
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b010, 3'd1, 4'd9, 8'hFE, 4'd7}, // 3  R7 other warp reads r1
        '{8'h02, 2'd0, 4'd2, 4'd6,  4'd7,  3'b000, 3'd0, 4'd0, 8'hFE, 4'd5}, // 4  R5 still stalled
        '{8'h04, 2'd1, 4'd3, 4'd6,  4'd7,  3'b001, 3'd0, 4'd4, 8'hFD, 4'd5}, // 5  R5 exact FP latency
        '{8'h08, 2'd1, 4'd1, 4'd8,  4'd9,  3'b010, 3'd2, 4'd3, 8'hFD, 4'd8}, // 6  R8 FP busy, INT goes
        '{8'h10, 2'd1, 4'd2, 4'd8,  4'd9,  3'b001, 3'd1, 4'd2, 8'hF7, 4'd8}, // 7  R8 FP during INT half2
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b010, 3'd3, 4'd1, 8'hEF, 4'd4}, // 8  R4 w3 before w4
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'hEF, 4'd9}, // 9  R9 bubble, INT busy
        '{8'h61, 2'd0, 4'd8, 4'd10, 4'd11, 3'b010, 3'd4, 4'd2, 8'hFF, 4'd8}, // 10 R8 INT reissue
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b001, 3'd5, 4'd8, 8'hBE, 4'd4}, // 11 R4 start after w4
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'hBE, 4'd8}, // 12 R8 FP busy
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b001, 3'd6, 4'd8, 8'hFE, 4'd4}, // 13 R4 w6
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'hFE, 4'd9}, // 14 R9
        '{8'h80, 2'd2, 4'd5, 4'd12, 4'd13, 3'b001, 3'd0, 4'd8, 8'hFF, 4'd4}, // 15 R4 wrap to w0
        '{8'h80, 2'd1, 4'd6, 4'd5,  4'd0,  3'b100, 3'd7, 4'd5, 8'hFF, 4'd3}, // 16 R3 matrix dispatch
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd5}, // 17 R5 matrix wait
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd5}, // 18
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd5}, // 19
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd5}, // 20
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd5}, // 21
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd5}, // 22
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd5}, // 23
        '{8'h80, 2'd0, 4'd6, 4'd0,  4'd0,  3'b010, 3'd7, 4'd6, 8'hFF, 4'd5}, // 24 R5 exact matrix latency
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd6}, // 25 R6 WAW wait
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd6}, // 26
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b000, 3'd0, 4'd0, 8'h7F, 4'd6}, // 27
        '{8'h00, 2'd0, 4'd0, 4'd0,  4'd0,  3'b001, 3'd7, 4'd6, 8'hFF, 4'd6}  // 28 R6 WAW release
    };

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic [NW-1:0]          fetch_valid = '0;
    logic [NW-1:0][1:0]     fetch_class = '0;
    logic [NW-1:0][RW-1:0]  fetch_dst = '0;
    logic [NW-1:0][RW-1:0]  fetch_src0 = '0;
    logic [NW-1:0][RW-1:0]  fetch_src1 = '0;
    logic [NW-1:0]          fetch_ready;
    logic [2:0]             disp_valid;
    logic [2:0]             disp_warp;
    logic [RW-1:0]          disp_dst;
    logic [RW-1:0]          disp_src0;
    logic [RW-1:0]          disp_src1;

    int n_checks = 0;
    int n_fail   = 0;

    warp_issue_sched i_warp_issue_sched (
        .clk         (clk),
        .rst         (rst),
        .fetch_valid (fetch_valid),
        .fetch_class (fetch_class),
        .fetch_dst   (fetch_dst),
        .fetch_src0  (fetch_src0),
        .fetch_src1  (fetch_src1),
        .fetch_ready (fetch_ready),
        .disp_valid  (disp_valid),
        .disp_warp   (disp_warp),
        .disp_dst    (disp_dst),
        .disp_src0   (disp_src0),
        .disp_src1   (disp_src1)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic string req_name(input logic [3:0] n);
        case (n)
            4'd1: return "R1";
            4'd2: return "R2";
            4'd3: return "R3";
            4'd4: return "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7: return "R7";
            4'd8: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic drive(input logic [7:0] fv, input logic [1:0] cls,
                         input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
        fetch_valid = fv;
        for (int w = 0; w < NW; w++) begin
            fetch_class[w] = cls;
            fetch_dst[w]   = d;
            fetch_src0[w]  = a;
            fetch_src1[w]  = b;
        end
    endtask

    task automatic expect_out(input string tag, input logic [2:0] ev, input logic [2:0] ew,
                              input logic [3:0] ed, input logic [7:0] er);
        logic bad;
        n_checks++;
        bad = (disp_valid !== ev) || (fetch_ready !== er);
        if (ev != 3'b000) bad = bad || (disp_warp !== ew) || (disp_dst !== ed);
        if (bad) begin
            n_fail++;
            $display("FAIL %s: valid=%b warp=%0d dst=%0d ready=%h, expected valid=%b warp=%0d dst=%0d ready=%h",
                     tag, disp_valid, disp_warp, disp_dst, fetch_ready, ev, ew, ed, er);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        expect_out("R1 reset", 3'b000, 3'd0, 4'd0, 8'hFF);

        for (int i = 0; i < NVEC; i++) begin
            expect_out($sformatf("%s vec%0d", req_name(VT[i].rq), i),
                       VT[i].ev, VT[i].ew, VT[i].ed, VT[i].er);
            drive(VT[i].fv, VT[i].cls, VT[i].dst, VT[i].s0, VT[i].s1);
            @(negedge clk);
        end

        // Directed: reset with a held slot and a pending register (R1)
        drive(8'h08, 2'd0, 4'd1, 4'd0, 4'd0);
        @(negedge clk);
        expect_out("R3 pre-reset float issue", 3'b001, 3'd3, 4'd1, 8'hFF);
        drive(8'h08, 2'd1, 4'd2, 4'd1, 4'd1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(8'h00, 2'd0, 4'd0, 4'd0, 4'd0);
        expect_out("R1 slot emptied by reset", 3'b000, 3'd0, 4'd0, 8'hFF);
        drive(8'h08, 2'd1, 4'd2, 4'd1, 4'd1);
        @(negedge clk);
        drive(8'h00, 2'd0, 4'd0, 4'd0, 4'd0);
        expect_out("R1 scoreboard cleared by reset", 3'b010, 3'd3, 4'd2, 8'hFF);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule